// File: doc/BRIEF.md
# Paged DMA Transfer Address Generator

This block generates the physical memory address for one DMA channel during a block transfer. It also signals the end of the block. Software, or a programming sequencer, loads three things: a 16-bit start address, a 16-bit transfer count and an 8-bit page number. Each pulse on `step` marks one completed transfer. On that pulse the channel advances its current address by one, lowers its remaining count by one, and presents the next physical address.

The 16-bit counters never carry into the page, so a block always stays inside one page. In byte mode a page is 64K bytes. In word mode a page is 128K bytes and the unit of transfer is a 16-bit word, so the address is shifted left by one and page bit 0 plays no part. The programmed count is one less than the number of transfers. The residue output reports the remaining transfers in bytes, so software can read back how much of the block is left. With auto-initialize on, the channel reloads its start address and count at the end of the block and keeps running.

Top module: `dpa_page_addr_gen`

## Requirements
- R1: With `word_mode`=0, `phys_addr` equals {page[7:0], current address[15:0]}.
- R2: With `word_mode`=1, `phys_addr` equals {page[7:1], current address[15:0], 1'b0}. Page bit 0 has no effect on it, and bit 0 of `phys_addr` is always 0.
- R3: A `step` accepted by an armed channel raises the current address by one and lowers the current count by one. Without a step or a load, `phys_addr` and `residue` hold their values.
- R4: The current address wraps from 0xFFFF to 0x0000 without changing the page, so the page bits of `phys_addr` never change because of a step.
- R5: A programmed count C yields exactly C+1 accepted steps before terminal count. A count of 0x0000 gives 1 step and 0xFFFF gives 65536 steps.
- R6: `residue` equals ((current count + 1) mod 65536) in byte mode and twice that value in word mode. It reads 0 once a block has finished without auto-initialize.
- R7: `tc_pulse` is high for exactly the one cycle that follows the step that consumed the last transfer, and is low otherwise.
- R8: With `auto_init`=0, a channel ignores steps after terminal count, and its address and residue stay put until the count is loaded again.
- R9: With `auto_init`=1, the final step of a block reloads the current address and count from the loaded start values, and the channel stays armed.
- R10: In a cycle where `load_addr` or `load_count` is high, a concurrent `step` is ignored and the loaded value takes effect.
- R11: After reset, address, count and page are 0, so `residue` is 1 in byte mode. The channel is unarmed and ignores steps until a count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1: 16-bit word channel, 0: byte channel |
| load_addr | input | 1 | Load start and current address from `addr_in` |
| addr_in | input | 16 | Start address value |
| load_count | input | 1 | Load start and current count from `count_in`; arms the channel |
| count_in | input | 16 | Programmed count (transfers minus one) |
| load_page | input | 1 | Load page from `page_in` |
| page_in | input | 8 | Page value |
| auto_init | input | 1 | Reload from start values at terminal count |
| step | input | 1 | One transfer completed |
| phys_addr | output | 24 | Physical memory address |
| tc_pulse | output | 1 | Terminal-count pulse |
| residue | output | 17 | Remaining transfers expressed in bytes |

## Verification
The assertions check four things on every cycle. The word-mode address is always even. The page field never moves except on a page load. Address and residue hold whenever the channel sees neither a step nor a load. A terminal-count pulse always follows a step, and without auto-initialize it leaves a zero residue. Other properties need the bench's sweeps over programmed counts in both modes: the exact step count (C+1) before the pulse, the wrap at 0xFFFF inside a page, the full 65536-transfer block, reload under auto-initialize, load priority over step, and steps being ignored once a block is finished.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    parameter int unsigned DPA_ADDR_W = 16;
    parameter int unsigned DPA_PAGE_W = 8;

    typedef struct packed {
        logic [DPA_ADDR_W-1:0] base_addr;
        logic [DPA_ADDR_W-1:0] base_cnt;
        logic [DPA_ADDR_W-1:0] cur_addr;
        logic [DPA_ADDR_W-1:0] cur_cnt;
        logic [DPA_PAGE_W-1:0] page;
        logic                  armed;
        logic                  tc;
    } dpa_state_t;
endpackage

// File: rtl/dpa_step_unit.sv
module dpa_step_unit #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cur_addr,
    input  logic [W-1:0] cur_cnt,
    output logic [W-1:0] addr_next,
    output logic [W-1:0] cnt_next,
    output logic         last_xfer
);
    // address wraps modulo 2^W; no carry leaves this unit
    assign addr_next = cur_addr + W'(1);
    assign cnt_next  = cur_cnt - W'(1);
    assign last_xfer = (cur_cnt == '0);
endmodule

// File: rtl/dpa_addr_map.sv
module dpa_addr_map #(
    parameter int unsigned AW = 16,
    parameter int unsigned PW = 8,
    localparam int unsigned OW = AW + PW
) (
    input  logic          word_mode,
    input  logic [PW-1:0] page,
    input  logic [AW-1:0] addr,
    output logic [OW-1:0] phys
);
    logic [OW-1:0] byte_phys;
    logic [OW-1:0] word_phys;

    assign byte_phys = {page, addr};
    // word channel: address counts 16-bit units, page bit 0 unused
    assign word_phys = {page[PW-1:1], addr, 1'b0};
    assign phys      = word_mode ? word_phys : byte_phys;
endmodule

// File: rtl/dpa_residue.sv
module dpa_residue #(
    parameter int unsigned AW = 16
) (
    input  logic          word_mode,
    input  logic [AW-1:0] cur_cnt,
    output logic [AW:0]   residue
);
    logic [AW-1:0] units;

    assign units   = cur_cnt + AW'(1);
    assign residue = word_mode ? {units, 1'b0} : {1'b0, units};
endmodule

// File: rtl/dpa_page_addr_gen.sv
module dpa_page_addr_gen
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = DPA_ADDR_W,
    parameter int unsigned PAGE_W = DPA_PAGE_W,
    localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              load_count,
    input  logic [ADDR_W-1:0] count_in,
    input  logic              load_page,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              auto_init,
    input  logic              step,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc_pulse,
    output logic [ADDR_W:0]   residue
);
    dpa_state_t st_d, st_q;

    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] cnt_next;
    logic              last_xfer;
    logic              step_ok;

    dpa_step_unit #(.W(ADDR_W)) u_step (
        .cur_addr  (st_q.cur_addr),
        .cur_cnt   (st_q.cur_cnt),
        .addr_next (addr_next),
        .cnt_next  (cnt_next),
        .last_xfer (last_xfer)
    );

    // loads of address or count take priority over a concurrent step
    assign step_ok = step && st_q.armed && !load_addr && !load_count;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (load_addr) begin
            st_d.base_addr = addr_in;
            st_d.cur_addr  = addr_in;
        end
        if (load_count) begin
            st_d.base_cnt = count_in;
            st_d.cur_cnt  = count_in;
            st_d.armed    = 1'b1;
        end
        if (load_page) begin
            st_d.page = page_in;
        end
        if (step_ok) begin
            if (last_xfer) begin
                st_d.tc = 1'b1;
                if (auto_init) begin
                    st_d.cur_addr = st_q.base_addr;
                    st_d.cur_cnt  = st_q.base_cnt;
                end else begin
                    st_d.cur_addr = addr_next;
                    st_d.cur_cnt  = cnt_next;
                    st_d.armed    = 1'b0;
                end
            end else begin
                st_d.cur_addr = addr_next;
                st_d.cur_cnt  = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dpa_addr_map #(.AW(ADDR_W), .PW(PAGE_W)) u_map (
        .word_mode (word_mode),
        .page      (st_q.page),
        .addr      (st_q.cur_addr),
        .phys      (phys_addr)
    );

    dpa_residue #(.AW(ADDR_W)) u_res (
        .word_mode (word_mode),
        .cur_cnt   (st_q.cur_cnt),
        .residue   (residue)
    );

    assign tc_pulse = st_q.tc;
endmodule

// File: rtl/dpa_page_addr_gen_chk.sv
module dpa_page_addr_gen_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 8,
    localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_mode,
    input logic              load_addr,
    input logic              load_count,
    input logic              load_page,
    input logic              auto_init,
    input logic              step,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              tc_pulse,
    input logic [ADDR_W:0]   residue
);
    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (phys_addr[0] == 1'b0)); // R2

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_page |=> ($stable(phys_addr[PHYS_W-1 -: PAGE_W-1]) || (word_mode != $past(word_mode)))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_addr && !load_count && !load_page)
        |=> (($stable(phys_addr) && $stable(residue)) || (word_mode != $past(word_mode)))); // R3

    AST_TC_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_pulse) |-> $past(step)); // R7

    AST_TC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(auto_init)) |-> (residue == '0)); // R6
endmodule

bind dpa_page_addr_gen dpa_page_addr_gen_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_mode  (word_mode),
    .load_addr  (load_addr),
    .load_count (load_count),
    .load_page  (load_page),
    .auto_init  (auto_init),
    .step       (step),
    .phys_addr  (phys_addr),
    .tc_pulse   (tc_pulse),
    .residue    (residue)
);

// File: tb/dpa_page_addr_gen_bench.sv
module dpa_page_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b0;
    logic        load_addr = 1'b0;
    logic [15:0] addr_in = '0;
    logic        load_count = 1'b0;
    logic [15:0] count_in = '0;
    logic        load_page = 1'b0;
    logic [7:0]  page_in = '0;
    logic        auto_init = 1'b0;
    logic        step = 1'b0;
    logic [23:0] phys_addr;
    logic        tc_pulse;
    logic [16:0] residue;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench-side expectation
    logic [15:0] m_addr = '0, m_cnt = '0, m_baddr = '0, m_bcnt = '0;
    logic [7:0]  m_page = '0;
    bit          m_armed = 1'b0;

    always #2.5 clk = ~clk;

    dpa_page_addr_gen u_dpa_page_addr_gen (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
        .load_addr(load_addr), .addr_in(addr_in),
        .load_count(load_count), .count_in(count_in),
        .load_page(load_page), .page_in(page_in),
        .auto_init(auto_init), .step(step),
        .phys_addr(phys_addr), .tc_pulse(tc_pulse), .residue(residue)
    );

    function automatic logic [23:0] exp_phys();
        return word_mode ? {m_page[7:1], m_addr, 1'b0} : {m_page, m_addr};
    endfunction

    function automatic logic [16:0] exp_res();
        logic [15:0] u = m_cnt + 16'd1;
        return word_mode ? {u, 1'b0} : {1'b0, u};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input bit exp_tc);
        chk({req, " phys"}, int'(phys_addr), int'(exp_phys()));
        chk({req, " residue"}, int'(residue), int'(exp_res()));
        chk({req, " tc"}, int'(tc_pulse), int'(exp_tc));
    endtask

    task automatic load_all(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p);
        load_addr = 1'b1; addr_in = a;
        load_count = 1'b1; count_in = c;
        load_page = 1'b1; page_in = p;
        @(negedge clk);
        load_addr = 1'b0; load_count = 1'b0; load_page = 1'b0;
        m_addr = a; m_baddr = a; m_cnt = c; m_bcnt = c; m_page = p; m_armed = 1'b1;
    endtask

    // one step; returns expected tc and updates the model
    task automatic do_step(output bit etc);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        etc = 1'b0;
        if (m_armed) begin
            if (m_cnt == 16'h0000) begin
                etc = 1'b1;
                if (auto_init) begin
                    m_addr = m_baddr; m_cnt = m_bcnt;
                end else begin
                    m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1; m_armed = 1'b0;
                end
            end else begin
                m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
            end
        end
    endtask

    initial begin
        bit etc;
        int tcs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state, unarmed
        chk("R11 phys", int'(phys_addr), 0);
        chk("R11 residue", int'(residue), 1);
        chk("R11 tc", int'(tc_pulse), 0);
        do_step(etc);
        chk_all("R11 step ignored unarmed", 1'b0);

        // R1 R2 R3 R5 R6 R7 R8: sweep of counts in both modes
        for (int mode = 0; mode < 2; mode++) begin
            word_mode = mode[0];
            for (int c = 0; c < 24; c++) begin
                load_all(16'(16'h1230 + c * 7), 16'(c), 8'(8'h41 + c));
                chk_all("R1 R2 after load", 1'b0);
                tcs = 0;
                for (int s = 0; s <= c; s++) begin
                    do_step(etc);
                    chk_all(mode ? "R2 R3 R5 word step" : "R1 R3 R5 byte step", etc);
                    if (tc_pulse) tcs++;
                end
                chk("R5 one terminal count", tcs, 1);
                chk("R6 zero residue at end", int'(residue), 0);
                do_step(etc);
                chk_all("R8 step after end ignored", 1'b0);
                @(negedge clk);
                chk_all("R7 pulse one cycle", 1'b0);
            end
        end

        // R2: page bit 0 ignored in word mode
        word_mode = 1'b1;
        load_all(16'h0400, 16'd3, 8'h57);
        chk("R2 page bit0 odd", int'(phys_addr), int'({7'h2B, 16'h0400, 1'b0}));
        load_page = 1'b1; page_in = 8'h56;
        @(negedge clk);
        load_page = 1'b0; m_page = 8'h56;
        chk("R2 page bit0 even", int'(phys_addr), int'({7'h2B, 16'h0400, 1'b0}));

        // R4: wrap inside page, both modes
        for (int mode = 0; mode < 2; mode++) begin
            word_mode = mode[0];
            load_all(16'hFFFE, 16'd5, 8'h35);
            for (int s = 0; s < 4; s++) begin
                do_step(etc);
                chk_all("R4 wrap in page", etc);
            end
            chk("R4 wrapped addr", int'(phys_addr),
                mode ? int'({7'h1A, 16'h0002, 1'b0}) : int'({8'h35, 16'h0002}));
        end

        // R9: auto-initialize
        word_mode = 1'b0;
        auto_init = 1'b1;
        load_all(16'h0100, 16'd2, 8'h09);
        tcs = 0;
        for (int s = 0; s < 7; s++) begin
            do_step(etc);
            chk_all("R9 auto reload", etc);
            if (tc_pulse) tcs++;
        end
        chk("R9 two blocks", tcs, 2);
        chk("R9 reloaded address", int'(phys_addr), int'({8'h09, 16'h0101}));
        auto_init = 1'b0;

        // R10: load wins over step
        load_all(16'h2000, 16'd9, 8'h02);
        step = 1'b1; load_addr = 1'b1; addr_in = 16'h3000;
        @(negedge clk);
        step = 1'b0; load_addr = 1'b0; m_addr = 16'h3000; m_baddr = 16'h3000;
        chk_all("R10 addr load over step", 1'b0);
        step = 1'b1; load_count = 1'b1; count_in = 16'd4;
        @(negedge clk);
        step = 1'b0; load_count = 1'b0; m_cnt = 16'd4; m_bcnt = 16'd4;
        chk_all("R10 count load over step", 1'b0);

        // R5: full 65536-transfer block in byte mode
        load_all(16'h0000, 16'hFFFF, 8'h01);
        tcs = 0;
        for (int s = 0; s < 65535; s++) begin
            do_step(etc);
            if (tc_pulse) tcs++;
        end
        chk("R5 no early tc", tcs, 0);
        chk("R5 last addr", int'(phys_addr), int'(24'h01FFFF));
        chk("R6 one left", int'(residue), 1);
        do_step(etc);
        chk_all("R5 R4 final step", 1'b1);
        chk("R4 page kept", int'(phys_addr), int'(24'h010000));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule